// File: doc/BRIEF.md
# Processor Operating-Mode and Trap-Level Controller

This block decides which operating mode a processor core is in: normal execution, the reset/error-debug mode (RED), the error mode, or the fatal-error mode. Each cycle it looks at a set of single-cycle event pulses: trap, first and second watchdog timeout, software reset, external reset, power-on reset, fatal-error detect, return-from-trap, and a software write that sets the RED bit. It picks the highest-priority event and moves to the next mode. The result depends on where the trap-level counter stands relative to MAXTL-1 and MAXTL.

The block keeps the trap-level counter itself. A fatal error raises a level output to the system, and the system is expected to answer with a power-on reset. The error mode normally lasts one cycle and then falls through to RED mode with a one-cycle watchdog-reset request. A configuration input can instead hold the core in error mode for debug. Trap vectoring, state save and restore, and datapath reset sequencing are left to neighbouring logic.

Top module: `proc_mode_ctrl`

## Requirements
- R1: Reset (rst_n low at a clock edge) and a power-on reset pulse force mode 01 (RED) and trap level MAXTL from any mode, fatal included, with wdr_req low. The mode encoding is 00 execute, 01 RED, 10 error, 11 fatal.
- R2: When several events arrive together, only the highest one acts. The order from highest to lowest is: power-on reset, external reset, fatal error, second watchdog, software reset, first watchdog, trap, return-from-trap, RED write.
- R3: In execute or RED mode, a trap or first watchdog timeout works as follows. Below MAXTL-1 the mode is kept. At MAXTL-1 the block enters RED. At MAXTL it enters error. In every case the trap level rises by one and saturates at MAXTL.
- R4: In execute or RED mode, a software reset enters RED when the trap level is below MAXTL and enters error when it is at MAXTL. The trap level rises by one and saturates at MAXTL.
- R5: A second watchdog timeout in execute or RED mode enters error mode and leaves the trap level unchanged.
- R6: In error mode with stop_on_error clear, the next cycle shows RED mode with wdr_req high for exactly that one cycle, and the trap level rises by one, saturating at MAXTL.
- R7: In error mode with stop_on_error set, the block stays in error with wdr_req low. Trap, software reset, both watchdogs, return-from-trap and RED write change neither the mode nor the trap level.
- R8: An external reset in execute, RED or error mode enters RED and raises the trap level by one, saturating at MAXTL.
- R9: A fatal-error pulse in a non-fatal mode enters mode 11 with fatal_err high and the trap level held. Only power-on reset leaves mode 11. Every other event, external reset included, is ignored there.
- R10: A return-from-trap lowers the trap level by one, with a floor of 0. In RED mode with ret_red low it returns to execute, and with ret_red high it stays in RED. In execute mode it stays in execute.
- R11: A RED write in execute mode enters RED with the trap level held. It has no effect in any other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_por | input | 1 | Power-on reset pulse |
| ev_ext_reset | input | 1 | Externally initiated reset pulse |
| ev_fatal | input | 1 | Fatal-error detect pulse |
| ev_wd_second | input | 1 | Second watchdog timeout pulse |
| ev_sw_reset | input | 1 | Software-initiated reset pulse |
| ev_wd_first | input | 1 | First watchdog timeout pulse |
| ev_trap | input | 1 | Trap taken pulse |
| ev_trap_return | input | 1 | Return-from-trap pulse |
| ret_red | input | 1 | RED bit value restored by the return-from-trap |
| ev_red_write | input | 1 | Software write of RED=1 |
| stop_on_error | input | 1 | Hold in error mode instead of passing through |
| mode | output | 2 | Current mode (00 exec, 01 RED, 10 error, 11 fatal) |
| trap_level | output | $clog2(MAXTL+1) | Current trap level |
| fatal_err | output | 1 | Fatal-error indication to the system |
| wdr_req | output | 1 | One-cycle watchdog-reset trap request |

## Verification
Mode, trap level and fatal_err are registered, so any event presented before a rising edge shows on them one edge later. A pass-through of error mode takes a second edge, and its wdr_req pulse appears on that second edge together with RED mode. The bench drives all inputs on the falling edge and steps its arithmetic model at each rising edge. It compares every output on the following falling edge, so each result is checked in exactly the cycle it is due. Every event is swept from every reachable trap level in execute, RED and held error mode, with stop_on_error both clear and set. All event pairs and a long pseudo-random stream then exercise the priority order.

// File: rtl/pmc_pkg.sv
// Shared types for the operating-mode controller.
// Assumes: event codes are numbered so that a lower code is a higher priority.
package pmc_pkg;

    typedef enum logic [1:0] {
        MODE_EXEC  = 2'b00,
        MODE_RED   = 2'b01,
        MODE_ERR   = 2'b10,
        MODE_FATAL = 2'b11
    } mode_e;

    localparam int NUM_REQ = 9;
    localparam int EV_W    = $clog2(NUM_REQ + 1);

    typedef enum logic [EV_W-1:0] {
        EV_NONE  = 4'd0,
        EV_POR   = 4'd1,
        EV_XRST  = 4'd2,
        EV_FATAL = 4'd3,
        EV_WD2   = 4'd4,
        EV_SRST  = 4'd5,
        EV_WD1   = 4'd6,
        EV_TRAP  = 4'd7,
        EV_RET   = 4'd8,
        EV_REDW  = 4'd9
    } event_e;

    typedef enum logic [1:0] {
        TL_HOLD = 2'd0,
        TL_INC  = 2'd1,
        TL_DEC  = 2'd2,
        TL_LOAD = 2'd3
    } tl_op_e;

endpackage

// File: rtl/pmc_evt_arb.sv
// Fixed-priority event selector.
// Input bit 0 is the highest priority. The output is the event code of the
// highest set bit, or EV_NONE when no bit is set. Purely combinational.
module pmc_evt_arb
    import pmc_pkg::*;
#(
    parameter int N = NUM_REQ
) (
    input  logic [N-1:0] req,
    output event_e       win
);

    // Scan from lowest to highest priority so the highest set bit wins last.
    always_comb begin
        win = EV_NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                win = event_e'(EV_W'(i + 1));
            end
        end
    end

endmodule

// File: rtl/pmc_tl_ctr.sv
// Trap-level counter with saturating increment, floored decrement and a load
// to MAXTL. Also flags the two thresholds that steer mode decisions.
// Assumes MAXTL >= 2.
module pmc_tl_ctr
    import pmc_pkg::*;
#(
    parameter int MAXTL = 5,
    parameter int TLW   = $clog2(MAXTL + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  tl_op_e         op,
    output logic [TLW-1:0] tl,
    output logic           at_max,
    output logic           at_lim
);

    localparam logic [TLW-1:0] TL_MAX = TLW'(MAXTL);
    localparam logic [TLW-1:0] TL_LIM = TLW'(MAXTL - 1);

    logic [TLW-1:0] tl_q;

    // Apply the requested counter operation each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tl_q <= TL_MAX;
        end else begin
            unique case (op)
                TL_LOAD: tl_q <= TL_MAX;
                TL_INC:  tl_q <= (tl_q == TL_MAX) ? tl_q : tl_q + 1'b1;
                TL_DEC:  tl_q <= (tl_q == '0) ? tl_q : tl_q - 1'b1;
                default: tl_q <= tl_q;
            endcase
        end
    end

    // Threshold flags for the next-mode logic.
    always_comb begin
        tl     = tl_q;
        at_max = (tl_q == TL_MAX);
        at_lim = (tl_q == TL_LIM);
    end

endmodule

// File: rtl/pmc_mode_next.sv
// Next-mode decision. From the current mode, the winning event and the
// trap-level thresholds it picks the next mode, the counter operation and
// whether a watchdog-reset request goes out with the next mode.
// Assumes at most one event code is presented (arbitration is done upstream).
module pmc_mode_next
    import pmc_pkg::*;
(
    input  mode_e  mode_q,
    input  event_e ev,
    input  logic   at_max,
    input  logic   at_lim,
    input  logic   ret_red,
    input  logic   stop_on_error,
    output mode_e  mode_d,
    output tl_op_e tl_op,
    output logic   wdr_d
);

    // Mode transition table.
    always_comb begin
        mode_d = mode_q;
        tl_op  = TL_HOLD;
        wdr_d  = 1'b0;
        if (ev == EV_POR) begin
            mode_d = MODE_RED;
            tl_op  = TL_LOAD;
        end else if (mode_q == MODE_FATAL) begin
            mode_d = MODE_FATAL;
        end else if (ev == EV_XRST) begin
            mode_d = MODE_RED;
            tl_op  = TL_INC;
        end else if (ev == EV_FATAL) begin
            mode_d = MODE_FATAL;
        end else if (mode_q == MODE_ERR) begin
            if (!stop_on_error) begin
                mode_d = MODE_RED;
                tl_op  = TL_INC;
                wdr_d  = 1'b1;
            end
        end else begin
            unique case (ev)
                EV_WD2: begin
                    mode_d = MODE_ERR;
                end
                EV_SRST: begin
                    mode_d = at_max ? MODE_ERR : MODE_RED;
                    tl_op  = TL_INC;
                end
                EV_WD1, EV_TRAP: begin
                    if (at_max) begin
                        mode_d = MODE_ERR;
                    end else if (at_lim) begin
                        mode_d = MODE_RED;
                    end
                    tl_op = TL_INC;
                end
                EV_RET: begin
                    tl_op = TL_DEC;
                    if (mode_q == MODE_RED && !ret_red) begin
                        mode_d = MODE_EXEC;
                    end
                end
                EV_REDW: begin
                    if (mode_q == MODE_EXEC) begin
                        mode_d = MODE_RED;
                    end
                end
                default: begin
                    mode_d = mode_q;
                end
            endcase
        end
    end

endmodule

// File: rtl/proc_mode_ctrl.sv
// Processor operating-mode and trap-level controller (top).
// Arbitrates single-cycle event pulses, tracks the trap level and holds the
// mode register. Assumes events are one-cycle pulses and MAXTL >= 2.
module proc_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int MAXTL = 5,
    localparam int TLW  = $clog2(MAXTL + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ev_por,
    input  logic           ev_ext_reset,
    input  logic           ev_fatal,
    input  logic           ev_wd_second,
    input  logic           ev_sw_reset,
    input  logic           ev_wd_first,
    input  logic           ev_trap,
    input  logic           ev_trap_return,
    input  logic           ret_red,
    input  logic           ev_red_write,
    input  logic           stop_on_error,
    output logic [1:0]     mode,
    output logic [TLW-1:0] trap_level,
    output logic           fatal_err,
    output logic           wdr_req
);

    logic [NUM_REQ-1:0] req;
    event_e             ev_win;
    mode_e              mode_q;
    mode_e              mode_d;
    tl_op_e             tl_op;
    logic               wdr_d;
    logic               wdr_q;
    logic               at_max;
    logic               at_lim;

    // Pack event pulses in priority order, bit 0 highest.
    always_comb begin
        req = {ev_red_write, ev_trap_return, ev_trap, ev_wd_first,
               ev_sw_reset, ev_wd_second, ev_fatal, ev_ext_reset, ev_por};
    end

    pmc_evt_arb #(.N(NUM_REQ)) arb_i (
        .req (req),
        .win (ev_win)
    );

    pmc_tl_ctr #(.MAXTL(MAXTL), .TLW(TLW)) tl_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (tl_op),
        .tl     (trap_level),
        .at_max (at_max),
        .at_lim (at_lim)
    );

    pmc_mode_next next_i (
        .mode_q        (mode_q),
        .ev            (ev_win),
        .at_max        (at_max),
        .at_lim        (at_lim),
        .ret_red       (ret_red),
        .stop_on_error (stop_on_error),
        .mode_d        (mode_d),
        .tl_op         (tl_op),
        .wdr_d         (wdr_d)
    );

    // Mode and watchdog-reset request registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RED;
            wdr_q  <= 1'b0;
        end else begin
            mode_q <= mode_d;
            wdr_q  <= wdr_d;
        end
    end

    // Drive outputs from the registered state.
    always_comb begin
        mode      = mode_q;
        fatal_err = (mode_q == MODE_FATAL);
        wdr_req   = wdr_q;
    end

endmodule

// File: rtl/pmc_checker.sv
// Property checker for proc_mode_ctrl, attached by bind below.
module pmc_checker #(
    parameter int MAXTL = 5,
    parameter int TLW   = $clog2(MAXTL + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           ev_por,
    input logic           ev_ext_reset,
    input logic           ev_fatal,
    input logic           ev_wd_second,
    input logic           stop_on_error,
    input logic [1:0]     mode,
    input logic [TLW-1:0] trap_level,
    input logic           wdr_req
);

    logic hi_evt;
    always_comb hi_evt = ev_por || ev_ext_reset || ev_fatal;

    // R1
    por_to_red_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_por |=> (mode == 2'b01 && trap_level == TLW'(MAXTL) && !wdr_req));

    // R9
    fatal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11 && !ev_por) |=> (mode == 2'b11));

    // R9
    fatal_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_fatal && !ev_por && !ev_ext_reset) |=> (mode == 2'b11));

    // R7
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && stop_on_error && !hi_evt) |=> (mode == 2'b10 && !wdr_req));

    // R6
    err_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && !stop_on_error && !hi_evt) |=> (mode == 2'b01 && wdr_req));

    // R6
    wdr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdr_req |-> ($past(mode) == 2'b10 && mode == 2'b01));

    // R5
    wd2_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_wd_second && !hi_evt && (mode == 2'b00 || mode == 2'b01)) |=>
        (mode == 2'b10 && $stable(trap_level)));

    // R3
    tl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_level <= TLW'(MAXTL));

endmodule

bind proc_mode_ctrl pmc_checker #(.MAXTL(MAXTL), .TLW(TLW)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_por        (ev_por),
    .ev_ext_reset  (ev_ext_reset),
    .ev_fatal      (ev_fatal),
    .ev_wd_second  (ev_wd_second),
    .stop_on_error (stop_on_error),
    .mode          (mode),
    .trap_level    (trap_level),
    .wdr_req       (wdr_req)
);

// File: tb/proc_mode_ctrl_tb_top.sv
// Self-checking bench: arithmetic model of the requirements, per-cycle compare.
module proc_mode_ctrl_tb_top;

    localparam int MAXTL = 5;
    localparam int TLW   = $clog2(MAXTL + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [8:0] req = '0;    // bit0 por .. bit8 red write
    logic ret_red = 1'b0;
    logic stop = 1'b0;
    logic [1:0] mode;
    logic [TLW-1:0] trap_level;
    logic fatal_err;
    logic wdr_req;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    int m_mode = 1;
    int m_tl = MAXTL;
    int m_wdr = 0;
    string tag = "R1";

    always #5 clk = ~clk;

    proc_mode_ctrl #(.MAXTL(MAXTL)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .ev_por(req[0]), .ev_ext_reset(req[1]), .ev_fatal(req[2]),
        .ev_wd_second(req[3]), .ev_sw_reset(req[4]), .ev_wd_first(req[5]),
        .ev_trap(req[6]), .ev_trap_return(req[7]), .ret_red(ret_red),
        .ev_red_write(req[8]), .stop_on_error(stop),
        .mode(mode), .trap_level(trap_level), .fatal_err(fatal_err), .wdr_req(wdr_req)
    );

    function automatic int inc_sat(int v);
        return (v >= MAXTL) ? MAXTL : v + 1;
    endfunction

    // Model one clock edge from the requirements.
    task automatic model_step(input logic [8:0] r, input bit rr, input bit st, input bit rst);
        int w;
        w = -1;
        for (int i = 8; i >= 0; i--) if (r[i]) w = i;
        m_wdr = 0;
        tag = ($countones(r) > 1) ? "R2" : "R1";
        if (rst || w == 0) begin
            m_mode = 1; m_tl = MAXTL;
            if (!($countones(r) > 1)) tag = "R1";
        end else if (m_mode == 3) begin
            if ($countones(r) <= 1) tag = "R9";
        end else if (w == 1) begin
            m_mode = 1; m_tl = inc_sat(m_tl);
            if ($countones(r) <= 1) tag = "R8";
        end else if (w == 2) begin
            m_mode = 3;
            if ($countones(r) <= 1) tag = "R9";
        end else if (m_mode == 2) begin
            if ($countones(r) <= 1) tag = st ? "R7" : "R6";
            if (!st) begin m_mode = 1; m_tl = inc_sat(m_tl); m_wdr = 1; end
        end else begin
            string t;
            t = "R1";
            case (w)
                3: begin m_mode = 2; t = "R5"; end
                4: begin m_mode = (m_tl == MAXTL) ? 2 : 1; m_tl = inc_sat(m_tl); t = "R4"; end
                5, 6: begin
                    if (m_tl == MAXTL) m_mode = 2;
                    else if (m_tl == MAXTL - 1) m_mode = 1;
                    m_tl = inc_sat(m_tl); t = "R3";
                end
                7: begin
                    if (m_tl > 0) m_tl = m_tl - 1;
                    if (m_mode == 1 && !rr) m_mode = 0;
                    t = "R10";
                end
                8: begin if (m_mode == 0) m_mode = 1; t = "R11"; end
                default: t = "R1";
            endcase
            if ($countones(r) <= 1) tag = t;
        end
    endtask

    task automatic check(input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    // One clock: inputs already driven; step model at the edge, compare at negedge.
    task automatic cycle(input logic [8:0] r, input bit rr);
        bit rst;
        req = r; ret_red = rr;
        rst = !rst_n;
        @(posedge clk);
        model_step(r, rr, stop, rst);
        @(negedge clk);
        check("mode", int'(mode), m_mode);
        check("trap_level", int'(trap_level), m_tl);
        check("wdr_req", int'(wdr_req), m_wdr);
        check("fatal_err", int'(fatal_err), (m_mode == 3) ? 1 : 0);
        req = '0; ret_red = 1'b0;
    endtask

    // Reach a given mode (0 exec, 1 RED, 2 held error) at trap level k.
    task automatic go_state(input int k, input int md);
        stop = 1'b1;
        cycle(9'b1, 1'b0);
        if (md == 0) begin
            for (int i = 0; i < MAXTL - k - 1; i++) cycle(9'h080, 1'b1);
            cycle(9'h080, 1'b0);
        end else begin
            for (int i = 0; i < MAXTL - k; i++) cycle(9'h080, 1'b1);
            if (md == 2) cycle(9'h008, 1'b0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        @(negedge clk);
        // R1: state under reset
        cycle('0, 1'b0);
        cycle(9'h1FF, 1'b1);
        rst_n = 1'b1;
        cycle('0, 1'b0);

        // Sweep: every event from every reachable level and mode, both stop settings.
        for (int md = 0; md < 3; md++) begin
            for (int k = 0; k <= MAXTL; k++) begin
                if (md == 0 && k == MAXTL) continue;
                for (int e = 0; e < 9; e++) begin
                    for (int s = 0; s < 2; s++) begin
                        for (int rr = 0; rr < 2; rr++) begin
                            if (rr == 1 && e != 7) continue;
                            go_state(k, md);
                            stop = s[0];
                            cycle(9'(1 << e), rr[0]);
                            cycle('0, 1'b0);
                            cycle(9'h002, 1'b0);   // R9 external reset ignored in fatal
                            cycle('0, 1'b0);
                        end
                    end
                end
            end
        end

        // R2: every pair of simultaneous events from execute at level 2.
        for (int a = 0; a < 9; a++) begin
            for (int b = a + 1; b < 9; b++) begin
                go_state(2, 0);
                stop = 1'b0;
                cycle(9'((1 << a) | (1 << b)), 1'b0);
                cycle('0, 1'b0);
            end
        end

        // Pseudo-random stream with sparse events and toggling stop.
        lfsr = 16'hACE1;
        for (int n = 0; n < 4000; n++) begin
            logic [8:0] r;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            r = '0;
            if (lfsr[2:0] < 3'd3) r[lfsr[6:3] % 9] = 1'b1;
            if (lfsr[9:7] == 3'd0) r[lfsr[13:10] % 9] = 1'b1;
            if (lfsr[15:11] == 5'd0) stop = ~stop;
            cycle(r, lfsr[14]);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule